// File: doc/BRIEF.md
# Line-Based Vertical Sequence Selector

This block picks which vertical timing sequence applies to each line of an image-sensor readout field. A field strobe starts a new field at line 0 and each line strobe moves to the next line. A small region table holds up to four region start lines, each with an enable bit and the sequence that the region opens with. A per-sequence flag table says what happens at the end of a line spent in that sequence: step to the next sequence number, go back to the region's opening sequence, or stay put.

With these two tables a short chain of sequences can loop over a whole region without listing every line. For example, one region starts at line 0 with sequence 2. Sequences 2 and 3 step forward and sequence 4 jumps back. A second region starts at line 6 with sequence 6. Lines 0 to 5 then run 2,3,4,2,3,4 and line 6 onward runs 6. The output is a registered sequence number that holds for the whole line. Both tables are written through simple write ports into staging copies, and these take effect only at the next field strobe, so a field in progress keeps the settings it started with.

Top module: `vseq_line_selector`

## Requirements
- R1: After reset `seq_o` is 0, all four region entries are disabled and every sequence has both flags clear.
- R2: At a line strobe with no region match, if the current sequence has its step flag set (`sf_adv`=1) and its return flag clear, the next line uses the current number plus one; 15 wraps to 0.
- R3: At a line strobe with no region match, if the current sequence has its return flag set (`sf_ret`=1), the next line uses the current region's opening sequence, whatever the step flag says.
- R4: `seq_o` changes only in the clock cycle right after a cycle with a field or line strobe; table writes and idle cycles leave it unchanged.
- R5: The line count becomes 0 on a field strobe and rises by one on each line strobe (it saturates at its maximum), and a field strobe wins over a line strobe in the same cycle. When the new line count equals the line of an enabled region entry, `seq_o` loads that entry's sequence. That value becomes the new return target and overrides both flags. If several enabled entries name the same line, the lowest index (0..3) wins.
- R6: A region entry with its enable bit clear never matches.
- R7: At a line strobe with no region match and both flags of the current sequence clear, `seq_o` keeps its value.
- R8: If no enabled region entry names line 0, a field strobe sets `seq_o` and the return target to 0.
- R9: Writes to either table only go to a staging copy. The copy becomes active at the next field strobe, so lines of the field in progress follow the old settings.
- R10: The two-region example in the description above gives 2,3,4,2,3,4,6,6 on lines 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vd_i | input | 1 | Field-start strobe, one cycle |
| hd_i | input | 1 | Line-start strobe, one cycle |
| rg_we | input | 1 | Region table write enable |
| rg_idx | input | 2 | Region entry index |
| rg_ena | input | 1 | Region entry enable bit |
| rg_line | input | 12 | Region start line |
| rg_seq | input | 4 | Region opening sequence |
| sf_we | input | 1 | Sequence flag table write enable |
| sf_idx | input | 4 | Sequence number whose flags are written |
| sf_adv | input | 1 | Step-forward flag |
| sf_ret | input | 1 | Return-to-region-start flag |
| seq_o | output | 4 | Sequence number for the current line |

## Verification
The properties assume that the strobes are single-cycle pulses and that a table write does not land in the same cycle as a field strobe. Under those conditions, the one-cycle step from strobe to `seq_o` is the only way the output can move. The stimulus raises each strobe for exactly one cycle and keeps writes on separate cycles from strobes. Table edits in the middle of a field are placed between line strobes only. The sweep walks every sequence number through all four flag combinations, with a region load partway into each field.

// File: rtl/vls_pkg.sv
package vls_pkg;

  // Per-sequence end-of-line behaviour flags.
  typedef struct packed {
    logic adv;   // step to the next sequence number
    logic ret;   // go back to the region's opening sequence
  } vls_flags_t;

  // What the engine does at the next register update.
  typedef enum logic [2:0] {
    ACT_IDLE,    // no strobe: keep everything
    ACT_LOAD,    // region match: load opening sequence
    ACT_CLEAR,   // field start without a line-0 region: go to 0
    ACT_RET,     // return to the base sequence
    ACT_ADV,     // step forward with wrap
    ACT_HOLD     // line strobe, nothing to change
  } vls_act_e;

endpackage

// File: rtl/vls_region_table.sv
module vls_region_table #(
  parameter int NUM_POS = 4,
  parameter int LINE_W  = 12,
  parameter int SEQ_W   = 4,
  parameter int IDX_W   = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_ena,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic              commit,
  input  logic [LINE_W-1:0] q_line,
  input  logic              q_stage,
  output logic              hit,
  output logic [SEQ_W-1:0]  hit_seq
);

  logic              st_en   [NUM_POS];
  logic [LINE_W-1:0] st_line [NUM_POS];
  logic [SEQ_W-1:0]  st_seq  [NUM_POS];
  logic              ac_en   [NUM_POS];
  logic [LINE_W-1:0] ac_line [NUM_POS];
  logic [SEQ_W-1:0]  ac_seq  [NUM_POS];
  logic [NUM_POS-1:0] match;
  logic [SEQ_W-1:0]  sel_seq [NUM_POS];

  for (genvar g = 0; g < NUM_POS; g++) begin : g_pos
    logic              sel_en;
    logic [LINE_W-1:0] sel_line;

    always_ff @(posedge clk) begin
      if (rst) begin
        st_en[g]   <= 1'b0;
        st_line[g] <= '0;
        st_seq[g]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        st_en[g]   <= wr_ena;
        st_line[g] <= wr_line;
        st_seq[g]  <= wr_seq;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ac_en[g]   <= 1'b0;
        ac_line[g] <= '0;
        ac_seq[g]  <= '0;
      end else if (commit) begin
        ac_en[g]   <= st_en[g];
        ac_line[g] <= st_line[g];
        ac_seq[g]  <= st_seq[g];
      end
    end

    // At a field start the staging copy is the one about to become active.
    assign sel_en     = q_stage ? st_en[g]   : ac_en[g];
    assign sel_line   = q_stage ? st_line[g] : ac_line[g];
    assign sel_seq[g] = q_stage ? st_seq[g]  : ac_seq[g];
    assign match[g]   = sel_en && (sel_line == q_line);
  end

  // Lowest index wins: scan from the top so the last assignment is the lowest.
  always_comb begin
    hit     = 1'b0;
    hit_seq = '0;
    for (int i = NUM_POS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_seq = sel_seq[i];
      end
    end
  end

endmodule

// File: rtl/vls_flag_table.sv
module vls_flag_table
  import vls_pkg::*;
#(
  parameter int NUM_SEQ = 16,
  parameter int SEQ_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_idx,
  input  logic             wr_adv,
  input  logic             wr_ret,
  input  logic             commit,
  input  logic [SEQ_W-1:0] rd_idx,
  output vls_flags_t       rd_flags
);

  vls_flags_t st_fl [NUM_SEQ];
  vls_flags_t ac_fl [NUM_SEQ];

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    always_ff @(posedge clk) begin
      if (rst) begin
        st_fl[g] <= '0;
      end else if (wr_en && wr_idx == SEQ_W'(g)) begin
        st_fl[g] <= '{adv: wr_adv, ret: wr_ret};
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ac_fl[g] <= '0;
      end else if (commit) begin
        ac_fl[g] <= st_fl[g];
      end
    end
  end

  always_comb begin
    rd_flags = '0;
    for (int i = 0; i < NUM_SEQ; i++) begin
      if (rd_idx == SEQ_W'(i)) rd_flags = ac_fl[i];
    end
  end

endmodule

// File: rtl/vls_seq_engine.sv
module vls_seq_engine
  import vls_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int SEQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vd,
  input  logic              hd,
  input  logic              hit,
  input  logic [SEQ_W-1:0]  hit_seq,
  input  vls_flags_t        flags,
  output logic [LINE_W-1:0] q_line,
  output logic              q_stage,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [SEQ_W-1:0]  base_o
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_nx;
  logic [SEQ_W-1:0]  seq_q;
  logic [SEQ_W-1:0]  base_q;
  vls_act_e          act;

  assign line_nx = (line_q == LINE_MAX) ? LINE_MAX : line_q + 1'b1;
  assign q_line  = vd ? '0 : line_nx;
  assign q_stage = vd;

  always_comb begin
    if (vd)             act = hit ? ACT_LOAD : ACT_CLEAR;
    else if (!hd)       act = ACT_IDLE;
    else if (hit)       act = ACT_LOAD;
    else if (flags.ret) act = ACT_RET;
    else if (flags.adv) act = ACT_ADV;
    else                act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (vd) begin
      line_q <= '0;
    end else if (hd) begin
      line_q <= line_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q  <= '0;
      base_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: begin
          seq_q  <= hit_seq;
          base_q <= hit_seq;
        end
        ACT_CLEAR: begin
          seq_q  <= '0;
          base_q <= '0;
        end
        ACT_RET:  seq_q <= base_q;
        ACT_ADV:  seq_q <= seq_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign seq_o  = seq_q;
  assign base_o = base_q;

endmodule

// File: rtl/vseq_line_selector.sv
module vseq_line_selector
  import vls_pkg::*;
#(
  parameter int NUM_POS = 4,
  parameter int NUM_SEQ = 16,
  parameter int SEQ_W   = 4,
  parameter int LINE_W  = 12,
  parameter int POS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vd_i,
  input  logic              hd_i,
  input  logic              rg_we,
  input  logic [POS_W-1:0]  rg_idx,
  input  logic              rg_ena,
  input  logic [LINE_W-1:0] rg_line,
  input  logic [SEQ_W-1:0]  rg_seq,
  input  logic              sf_we,
  input  logic [SEQ_W-1:0]  sf_idx,
  input  logic              sf_adv,
  input  logic              sf_ret,
  output logic [SEQ_W-1:0]  seq_o
);

  logic              scp_hit;
  logic [SEQ_W-1:0]  scp_seq;
  logic [LINE_W-1:0] q_line;
  logic              q_stage;
  logic [SEQ_W-1:0]  base_seq;
  logic [SEQ_W-1:0]  cur_seq;
  vls_flags_t        cur_flags;
  logic              flag_adv;
  logic              flag_ret;

  assign flag_adv = cur_flags.adv;
  assign flag_ret = cur_flags.ret;

  vls_region_table #(
    .NUM_POS (NUM_POS),
    .LINE_W  (LINE_W),
    .SEQ_W   (SEQ_W),
    .IDX_W   (POS_W)
  ) u_regions (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rg_we),
    .wr_idx  (rg_idx),
    .wr_ena  (rg_ena),
    .wr_line (rg_line),
    .wr_seq  (rg_seq),
    .commit  (vd_i),
    .q_line  (q_line),
    .q_stage (q_stage),
    .hit     (scp_hit),
    .hit_seq (scp_seq)
  );

  vls_flag_table #(
    .NUM_SEQ (NUM_SEQ),
    .SEQ_W   (SEQ_W)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (sf_we),
    .wr_idx   (sf_idx),
    .wr_adv   (sf_adv),
    .wr_ret   (sf_ret),
    .commit   (vd_i),
    .rd_idx   (cur_seq),
    .rd_flags (cur_flags)
  );

  vls_seq_engine #(
    .LINE_W (LINE_W),
    .SEQ_W  (SEQ_W)
  ) u_engine (
    .clk     (clk),
    .rst     (rst),
    .vd      (vd_i),
    .hd      (hd_i),
    .hit     (scp_hit),
    .hit_seq (scp_seq),
    .flags   (cur_flags),
    .q_line  (q_line),
    .q_stage (q_stage),
    .seq_o   (cur_seq),
    .base_o  (base_seq)
  );

  assign seq_o = cur_seq;

endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
  parameter int SEQ_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             vd,
  input logic             hd,
  input logic             hit,
  input logic [SEQ_W-1:0] hit_seq,
  input logic             adv,
  input logic             ret,
  input logic [SEQ_W-1:0] base,
  input logic [SEQ_W-1:0] seq_o
);

  a_r4_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (!vd && !hd) |=> $stable(seq_o));

  a_r2_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (hd && !vd && !hit && adv && !ret) |=> seq_o == SEQ_W'($past(seq_o) + 1'b1));

  a_r3_return_to_base: assert property (@(posedge clk) disable iff (rst)
    (hd && !vd && !hit && ret) |=> seq_o == $past(base));

  a_r5_region_load: assert property (@(posedge clk) disable iff (rst)
    ((vd || hd) && hit) |=> (seq_o == $past(hit_seq)) && (base == $past(hit_seq)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (hd && !vd && !hit && !adv && !ret) |=> $stable(seq_o));

  a_r8_field_no_region: assert property (@(posedge clk) disable iff (rst)
    (vd && !hit) |=> (seq_o == '0) && (base == '0));

endmodule

bind vseq_line_selector vls_checker #(.SEQ_W(SEQ_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .vd      (vd_i),
  .hd      (hd_i),
  .hit     (scp_hit),
  .hit_seq (scp_seq),
  .adv     (flag_adv),
  .ret     (flag_ret),
  .base    (base_seq),
  .seq_o   (seq_o)
);

// File: tb/vseq_line_selector_tb.sv
`timescale 1ns/1ps
module vseq_line_selector_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vd_i = 1'b0, hd_i = 1'b0;
  logic        rg_we = 1'b0, rg_ena = 1'b0;
  logic [1:0]  rg_idx = '0;
  logic [11:0] rg_line = '0;
  logic [3:0]  rg_seq = '0;
  logic        sf_we = 1'b0, sf_adv = 1'b0, sf_ret = 1'b0;
  logic [3:0]  sf_idx = '0;
  logic [3:0]  seq_o;

  int n_run = 0;
  int n_fail = 0;

  // Bench model of the tables (staging and active) and of the line state.
  bit        ms_en[4], ma_en[4];
  int        ms_ln[4], ma_ln[4];
  bit [3:0]  ms_sq[4], ma_sq[4];
  bit        ms_adv[16], ms_ret[16], ma_adv[16], ma_ret[16];
  int        m_line;
  bit [3:0]  m_seq, m_base;

  always #2 clk = ~clk;

  vseq_line_selector u_dut (
    .clk(clk), .rst(rst), .vd_i(vd_i), .hd_i(hd_i),
    .rg_we(rg_we), .rg_idx(rg_idx), .rg_ena(rg_ena), .rg_line(rg_line), .rg_seq(rg_seq),
    .sf_we(sf_we), .sf_idx(sf_idx), .sf_adv(sf_adv), .sf_ret(sf_ret),
    .seq_o(seq_o)
  );

  task automatic check(input string tag, input bit [3:0] exp);
    n_run++;
    if (seq_o !== exp) begin
      n_fail++;
      $display("FAIL %s: seq_o=%0d expected %0d", tag, seq_o, exp);
    end
  endtask

  task automatic wr_region(input int i, input bit en, input int ln, input bit [3:0] sq);
    @(negedge clk);
    rg_we = 1'b1; rg_idx = 2'(i); rg_ena = en; rg_line = 12'(ln); rg_seq = sq;
    @(negedge clk);
    rg_we = 1'b0;
    ms_en[i] = en; ms_ln[i] = ln; ms_sq[i] = sq;
  endtask

  task automatic wr_flags(input int s, input bit a, input bit r);
    @(negedge clk);
    sf_we = 1'b1; sf_idx = 4'(s); sf_adv = a; sf_ret = r;
    @(negedge clk);
    sf_we = 1'b0;
    ms_adv[s] = a; ms_ret[s] = r;
  endtask

  function automatic bit m_match(input int ln, output bit [3:0] sq);
    for (int i = 3; i >= 0; i--) begin
      if (ma_en[i] && ma_ln[i] == ln) begin
        sq = ma_sq[i];
        m_match = 1'b1;
        return m_match;
      end
    end
    sq = 4'd0;
    return 1'b0;
  endfunction

  // One-cycle strobe; seq_o is sampled one clock after it.
  task automatic strobe(input bit v, input bit h);
    bit [3:0] hs;
    bit       hm;
    @(negedge clk);
    vd_i = v; hd_i = h;
    @(negedge clk);
    vd_i = 1'b0; hd_i = 1'b0;
    if (v) begin
      for (int i = 0; i < 4; i++) begin
        ma_en[i] = ms_en[i]; ma_ln[i] = ms_ln[i]; ma_sq[i] = ms_sq[i];
      end
      for (int s = 0; s < 16; s++) begin
        ma_adv[s] = ms_adv[s]; ma_ret[s] = ms_ret[s];
      end
      m_line = 0;
      hm = m_match(0, hs);
      m_seq = hm ? hs : 4'd0;
      m_base = m_seq;
    end else if (h) begin
      if (m_line < 4095) m_line++;
      hm = m_match(m_line, hs);
      if (hm) begin
        m_seq = hs; m_base = hs;
      end else if (ma_ret[m_seq]) m_seq = m_base;
      else if (ma_adv[m_seq]) m_seq = m_seq + 4'd1;
    end
  endtask

  task automatic clear_tables();
    for (int i = 0; i < 4; i++) wr_region(i, 1'b0, 0, 4'd0);
    for (int s = 0; s < 16; s++) wr_flags(s, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      ms_en[i] = 0; ma_en[i] = 0; ms_ln[i] = 0; ma_ln[i] = 0; ms_sq[i] = 0; ma_sq[i] = 0;
    end
    for (int s = 0; s < 16; s++) begin
      ms_adv[s] = 0; ms_ret[s] = 0; ma_adv[s] = 0; ma_ret[s] = 0;
    end
    m_line = 0; m_seq = 0; m_base = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset value", 4'd0);
    strobe(1'b1, 1'b0);
    check("R1 tables cleared after reset", 4'd0);

    // R10: the two-region example.
    wr_region(0, 1'b1, 0, 4'd2);
    wr_region(1, 1'b1, 6, 4'd6);
    wr_flags(2, 1'b1, 1'b0);
    wr_flags(3, 1'b1, 1'b0);
    wr_flags(4, 1'b0, 1'b1);
    strobe(1'b1, 1'b0);
    check("R10 line 0", 4'd2);
    begin
      bit [3:0] exp_l[8] = '{4'd2, 4'd3, 4'd4, 4'd2, 4'd3, 4'd4, 4'd6, 4'd6};
      for (int l = 1; l < 8; l++) begin
        strobe(1'b0, 1'b1);
        check("R10 example line", exp_l[l]);
      end
    end

    // R4: idle cycles and table writes do not move the output.
    wr_flags(6, 1'b1, 1'b0);
    wr_region(2, 1'b1, 8, 4'd9);
    repeat (5) @(negedge clk);
    check("R4 stable between strobes", 4'd6);

    // R9: the writes above are staged; this field still holds sequence 6.
    strobe(1'b0, 1'b1);
    check("R9 staged write not yet active", 4'd6);
    strobe(1'b1, 1'b0);
    check("R9 field start", 4'd2);
    for (int l = 1; l <= 8; l++) strobe(1'b0, 1'b1);
    check("R9 staged region active next field", 4'd9);

    // R5: field strobe wins over a simultaneous line strobe.
    strobe(1'b1, 1'b1);
    check("R5 field wins over line", 4'd2);

    // R5: tie on the same line, lowest index wins.
    clear_tables();
    wr_region(3, 1'b1, 1, 4'd8);
    wr_region(1, 1'b1, 1, 4'd5);
    strobe(1'b1, 1'b0);
    check("R8 no line-0 region", 4'd0);
    strobe(1'b0, 1'b1);
    check("R5 lowest index wins", 4'd5);

    // R6: disabled entries never match, including at line 0.
    clear_tables();
    wr_region(0, 1'b0, 0, 4'd9);
    wr_region(2, 1'b0, 2, 4'd7);
    wr_region(1, 1'b1, 0, 4'd3);
    strobe(1'b1, 1'b0);
    check("R6 enabled entry at line 0", 4'd3);
    strobe(1'b0, 1'b1);
    strobe(1'b0, 1'b1);
    check("R6 disabled entry ignored", 4'd3);

    // Sweep: every sequence with every flag combination, load at line 3.
    clear_tables();
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 4; f++) begin
        string tg;
        tg = (f == 0) ? "R7 hold" : (f == 1) ? "R2 step" : "R3 return";
        wr_flags(s, f[0], f[1]);
        wr_flags((s + 1) % 16, 1'b0, 1'b0);
        wr_region(0, 1'b1, 0, 4'(s));
        wr_region(1, 1'b1, 3, 4'(s ^ 5));
        strobe(1'b1, 1'b0);
        check("R5 region load at field start", m_seq);
        for (int l = 1; l <= 4; l++) begin
          strobe(1'b0, 1'b1);
          check((l == 3) ? "R5 region load overrides flags" : tg, m_seq);
        end
        wr_flags(s, 1'b0, 1'b0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule